// File: doc/BRIEF.md
# Debug Trace Trigger and Breakpoint Controller

This block sits beside a CPU core and watches its bus. Two trigger comparators (A and B) share one trigger, which either marks the point where a trace run ends or the point where it starts. The trigger fires on a plain address match, or on a tagged opcode whose fetch matched and which is now about to execute. While a run is armed, the block writes the observed bus address into a circular trace buffer of `DEPTH` entries. It drives the buffer's write port directly.

A 3-bit run setup picks the trigger role, the trigger kind and whether a CPU breakpoint follows. A third comparator (C) raises breakpoint requests of its own. These do not depend on the armed state and never change it. Every breakpoint request is either forced or tagged. The route select bit sends it to a debug-mode entry line or to a software-interrupt line. All outputs are registered, so each one follows the bus cycle that caused it by one clock. After reset the block is idle and disarmed, and it has no way to request a system reset.

Top module: `dbg_trace_brk`

## Requirements
- R1: After synchronous reset, `armed`, `trace_full`, `trace_we`, `dbg_req`, `swi_req` and `req_tagged` are 0, and `trace_waddr` is 0.
- R2: When `dbg_en`=1 and the block is disarmed, a cycle with `arm_req` sets `armed` on the next cycle, clears `trace_full` and restarts writing at entry 0. `disarm_req` clears `armed` and wins over `arm_req`. While `dbg_en`=0, `armed` is held at 0.
- R3: In `run_setup[2]`=0 (end-trigger role) while armed, every cycle with `bus_valid` produces, one cycle later, `trace_we`=1 with `trace_wdata` equal to the bus address and `trace_waddr` one above the previous write, modulo `DEPTH`.
- R4: With `run_setup[1]`=0, the trigger is a valid bus cycle whose address equals `cmp_a_addr` or `cmp_b_addr`. In the end-trigger role, that cycle is still captured, then `armed` clears and no further writes occur.
- R5: With `run_setup[1]`=1, a valid cycle with `fetch_tag` at an A/B address latches a pending tag. The trigger fires on a later cycle with `exec_tag`. A `pipe_flush` before that discards the tag, so the following `exec_tag` has no effect.
- R6: In `run_setup[2]`=1 (begin-trigger role), no write occurs before the trigger. The trigger cycle is written to entry 0 when it is a valid cycle, and capture continues after it.
- R7: The `DEPTH`-th capture since arming sets `trace_full`. In the begin role, `armed` also clears and capture stops. In the end role, capture continues and wraps to entry 0.
- R8: With `run_setup[0]`=1 in the end role, a breakpoint request issues one cycle after the trigger. `req_tagged` is 0 for an address trigger and 1 for an opcode trigger. With `run_setup[0]`=0, no request issues.
- R9: With `run_setup[0]`=1 in the begin role, a forced request (`req_tagged`=0) issues with the `DEPTH`-th capture and not at the trigger.
- R10: When `cmpc_en`=1, a valid cycle at `cmp_c_addr` raises a request whether or not the block is armed, and it leaves `armed` unchanged. With `cmpc_tagged`=0 the request is forced and issues at that cycle. With `cmpc_tagged`=1 the cycle must carry `fetch_tag`, and the tagged request issues at the next `exec_tag`.
- R11: While `loop1_mode`=1, comparator C raises no request.
- R12: Each request appears on `dbg_req` when `route_dbg`=1 and on `swi_req` when it is 0. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_en | input | 1 | Block enable |
| arm_req | input | 1 | Arm a trace run |
| disarm_req | input | 1 | Abort the run |
| run_setup | input | 3 | {begin role, opcode trigger, breakpoint} |
| loop1_mode | input | 1 | Suppresses comparator C requests |
| cmpc_en | input | 1 | Comparator C breakpoint enable |
| cmpc_tagged | input | 1 | Comparator C request kind: 1 tagged, 0 forced |
| route_dbg | input | 1 | 1 routes requests to debug mode, 0 to software interrupt |
| cmp_a_addr | input | ADDR_W | Comparator A address |
| cmp_b_addr | input | ADDR_W | Comparator B address |
| cmp_c_addr | input | ADDR_W | Comparator C address |
| bus_valid | input | 1 | Bus cycle present |
| bus_addr | input | ADDR_W | Bus address |
| fetch_tag | input | 1 | Current cycle is a tagged opcode fetch |
| exec_tag | input | 1 | The tagged opcode is about to execute |
| pipe_flush | input | 1 | Pipeline flush; drops pending tags |
| trace_we | output | 1 | Trace buffer write strobe |
| trace_waddr | output | $clog2(DEPTH) | Trace buffer write entry |
| trace_wdata | output | ADDR_W | Captured bus address |
| armed | output | 1 | Run in progress |
| trace_full | output | 1 | Buffer filled since arming |
| dbg_req | output | 1 | Debug-mode entry request |
| swi_req | output | 1 | Software-interrupt request |
| req_tagged | output | 1 | Current request is tagged |

## Verification
The hardest state to reach is the forced request at buffer exhaustion in the begin role. It needs a trigger followed by exactly `DEPTH` captures. The bench reaches it with a loop of valid bus cycles at non-matching addresses and confirms that nothing issued one capture earlier. A flushed tag is also hard to see from outside. The bench shows that it was discarded by issuing an `exec_tag` afterwards and observing no request and no drop of `armed`.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    typedef struct packed {
        logic start_role;   // 1: trigger begins the run
        logic op_trig;      // 1: trigger on tagged opcode execution
        logic brk;          // 1: raise a breakpoint request
    } run_setup_t;

    typedef enum logic {
        REQ_FORCED = 1'b0,
        REQ_TAGGED = 1'b1
    } req_kind_t;

    typedef struct packed {
        logic      valid;
        req_kind_t kind;
    } brk_req_t;

    function automatic run_setup_t decode_setup(input logic [2:0] code);
        run_setup_t s;
        s.start_role = code[2];
        s.op_trig    = code[1];
        s.brk        = code[0];
        return s;
    endfunction

    function automatic brk_req_t merge_req(input brk_req_t a, input brk_req_t b);
        brk_req_t m;
        m.valid = a.valid | b.valid;
        m.kind  = ((a.valid && a.kind == REQ_TAGGED) || (b.valid && b.kind == REQ_TAGGED))
                  ? REQ_TAGGED : REQ_FORCED;
        return m;
    endfunction

endpackage

// File: rtl/dbg_addr_cmp.sv
module dbg_addr_cmp #(
    parameter int ADDR_W = 16,
    parameter int NCMP   = 3
) (
    input  logic [NCMP-1:0][ADDR_W-1:0] ref_addr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_valid,
    output logic [NCMP-1:0]             hit
);
    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        assign hit[i] = bus_valid && (bus_addr == ref_addr[i]);
    end
endmodule

// File: rtl/dbg_tag_slot.sv
module dbg_tag_slot (
    input  logic clk,
    input  logic rst,
    input  logic latch,
    input  logic exec,
    input  logic flush,
    input  logic clear,
    output logic fire
);
    logic pend;

    assign fire = pend && exec && !flush && !clear;

    always_ff @(posedge clk) begin
        if (rst || clear || flush) begin
            pend <= 1'b0;
        end else if (latch) begin
            pend <= 1'b1;
        end else if (exec) begin
            pend <= 1'b0;
        end
    end
endmodule

// File: rtl/dbg_trace_seq.sv
module dbg_trace_seq
    import dbg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 64,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              arm_req,
    input  logic              disarm_req,
    input  run_setup_t        setup,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              trig,
    output logic              armed,
    output logic              started,
    output logic              full,
    output logic              fill_done,
    output logic              we,
    output logic [PTR_W-1:0]  waddr,
    output logic [ADDR_W-1:0] wdata
);
    logic [PTR_W-1:0] ptr;
    logic             cap;
    logic             last;
    logic             end_hit;

    assign cap       = armed && bus_valid && (!setup.start_role || started || trig);
    assign last      = cap && (ptr == PTR_W'(DEPTH - 1));
    assign end_hit   = armed && !setup.start_role && trig;
    assign fill_done = last && setup.start_role;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            started <= 1'b0;
            full    <= 1'b0;
            ptr     <= '0;
            we      <= 1'b0;
            waddr   <= '0;
            wdata   <= '0;
        end else begin
            we <= cap;
            if (cap) begin
                waddr <= ptr;
                wdata <= bus_addr;
                ptr   <= ptr + PTR_W'(1);
            end
            if (last) begin
                full <= 1'b1;
            end
            if (armed && trig && setup.start_role) begin
                started <= 1'b1;
            end
            if (!en || disarm_req) begin
                armed <= 1'b0;
            end else if (arm_req && !armed) begin
                armed   <= 1'b1;
                started <= 1'b0;
                full    <= 1'b0;
                ptr     <= '0;
            end else if (end_hit || fill_done) begin
                armed <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dbg_trace_brk.sv
module dbg_trace_brk
    import dbg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 64,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dbg_en,
    input  logic              arm_req,
    input  logic              disarm_req,
    input  logic [2:0]        run_setup,
    input  logic              loop1_mode,
    input  logic              cmpc_en,
    input  logic              cmpc_tagged,
    input  logic              route_dbg,
    input  logic [ADDR_W-1:0] cmp_a_addr,
    input  logic [ADDR_W-1:0] cmp_b_addr,
    input  logic [ADDR_W-1:0] cmp_c_addr,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              fetch_tag,
    input  logic              exec_tag,
    input  logic              pipe_flush,
    output logic              trace_we,
    output logic [PTR_W-1:0]  trace_waddr,
    output logic [ADDR_W-1:0] trace_wdata,
    output logic              armed,
    output logic              trace_full,
    output logic              dbg_req,
    output logic              swi_req,
    output logic              req_tagged
);
    localparam int NCMP = 3;

    run_setup_t              setup;
    logic [NCMP-1:0]         hit;
    logic                    hit_ab, hit_c;
    logic                    started, fill_done;
    logic                    trig_live, addr_trig, op_fire, trig;
    logic                    ab_latch, ab_clear, ab_fire;
    logic                    c_ok, c_latch, c_clear, c_fire;
    brk_req_t                run_req, c_req, any_req;

    assign setup = decode_setup(run_setup);

    dbg_addr_cmp #(.ADDR_W(ADDR_W), .NCMP(NCMP)) u_cmp (
        .ref_addr  ({cmp_c_addr, cmp_b_addr, cmp_a_addr}),
        .bus_addr  (bus_addr),
        .bus_valid (bus_valid),
        .hit       (hit)
    );

    assign hit_ab = hit[0] || hit[1];
    assign hit_c  = hit[2];

    // Trigger path for comparators A/B
    assign trig_live = armed && !(setup.start_role && started);
    assign addr_trig = trig_live && !setup.op_trig && hit_ab;
    assign ab_latch  = trig_live && setup.op_trig && hit_ab && fetch_tag;
    assign ab_clear  = !trig_live || !setup.op_trig;

    dbg_tag_slot u_ab_slot (
        .clk   (clk),
        .rst   (rst),
        .latch (ab_latch),
        .exec  (exec_tag),
        .flush (pipe_flush),
        .clear (ab_clear),
        .fire  (ab_fire)
    );

    assign op_fire = ab_fire && trig_live && setup.op_trig;
    assign trig    = addr_trig || op_fire;

    dbg_trace_seq #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .en         (dbg_en),
        .arm_req    (arm_req),
        .disarm_req (disarm_req),
        .setup      (setup),
        .bus_valid  (bus_valid),
        .bus_addr   (bus_addr),
        .trig       (trig),
        .armed      (armed),
        .started    (started),
        .full       (trace_full),
        .fill_done  (fill_done),
        .we         (trace_we),
        .waddr      (trace_waddr),
        .wdata      (trace_wdata)
    );

    // Run breakpoint: at trigger in end role, at exhaustion in begin role
    always_comb begin
        run_req = '{valid: 1'b0, kind: REQ_FORCED};
        if (setup.brk && armed) begin
            if (!setup.start_role && trig) begin
                run_req.valid = 1'b1;
                run_req.kind  = setup.op_trig ? REQ_TAGGED : REQ_FORCED;
            end else if (fill_done) begin
                run_req.valid = 1'b1;
                run_req.kind  = REQ_FORCED;
            end
        end
    end

    // Comparator C: independent of the armed state
    assign c_ok    = dbg_en && cmpc_en && !loop1_mode;
    assign c_latch = c_ok && cmpc_tagged && hit_c && fetch_tag;
    assign c_clear = !c_ok || !cmpc_tagged;

    dbg_tag_slot u_c_slot (
        .clk   (clk),
        .rst   (rst),
        .latch (c_latch),
        .exec  (exec_tag),
        .flush (pipe_flush),
        .clear (c_clear),
        .fire  (c_fire)
    );

    always_comb begin
        c_req = '{valid: 1'b0, kind: REQ_FORCED};
        if (c_ok && !cmpc_tagged && hit_c) begin
            c_req.valid = 1'b1;
        end else if (c_fire) begin
            c_req.valid = 1'b1;
            c_req.kind  = REQ_TAGGED;
        end
    end

    assign any_req = merge_req(run_req, c_req);

    always_ff @(posedge clk) begin
        if (rst) begin
            dbg_req    <= 1'b0;
            swi_req    <= 1'b0;
            req_tagged <= 1'b0;
        end else begin
            dbg_req    <= any_req.valid && route_dbg;
            swi_req    <= any_req.valid && !route_dbg;
            req_tagged <= any_req.valid && (any_req.kind == REQ_TAGGED);
        end
    end
endmodule

// File: rtl/dbg_trace_brk_chk.sv
module dbg_trace_brk_chk #(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 64,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic             dbg_en,
    input logic             arm_req,
    input logic             disarm_req,
    input logic             trace_we,
    input logic [PTR_W-1:0] trace_waddr,
    input logic             armed,
    input logic             dbg_req,
    input logic             swi_req
);
    // R12: one target per request
    a_r12_one_target: assert property (@(posedge clk) disable iff (rst)
        !(dbg_req && swi_req));

    // R2: disarm takes priority
    a_r2_disarm_wins: assert property (@(posedge clk) disable iff (rst)
        disarm_req |=> !armed);

    // R2: disabled block cannot be armed
    a_r2_disabled_idle: assert property (@(posedge clk) disable iff (rst)
        !dbg_en |=> !armed);

    // R3: back-to-back writes advance the entry by one
    a_r3_ptr_step: assert property (@(posedge clk) disable iff (rst)
        trace_we |=> (!trace_we || trace_waddr == PTR_W'($past(trace_waddr) + PTR_W'(1))));

    // R4: no capture while disarmed
    a_r4_idle_no_write: assert property (@(posedge clk) disable iff (rst)
        !armed |=> !trace_we);
endmodule

bind dbg_trace_brk dbg_trace_brk_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .dbg_en      (dbg_en),
    .arm_req     (arm_req),
    .disarm_req  (disarm_req),
    .trace_we    (trace_we),
    .trace_waddr (trace_waddr),
    .armed       (armed),
    .dbg_req     (dbg_req),
    .swi_req     (swi_req)
);

// File: tb/tb_dbg_trace_brk.sv
`timescale 1ns/1ps
module tb_dbg_trace_brk;
    localparam int ADDR_W = 16;
    localparam int DEPTH  = 64;
    localparam int PTR_W  = $clog2(DEPTH);
    localparam logic [15:0] A_ADDR = 16'h8000;
    localparam logic [15:0] B_ADDR = 16'h8004;
    localparam logic [15:0] C_ADDR = 16'h9000;

    // {valid, addr, exp_we, exp_waddr}, end role, address trigger, no breakpoint
    localparam int NVEC = 8;
    localparam logic [23:0] VEC [NVEC] = '{
        {1'b1, 16'h1000, 1'b1, 6'd0},
        {1'b0, 16'h1002, 1'b0, 6'd0},
        {1'b1, 16'h1004, 1'b1, 6'd1},
        {1'b1, 16'h1006, 1'b1, 6'd2},
        {1'b0, 16'h8000, 1'b0, 6'd0},
        {1'b1, 16'h8004, 1'b1, 6'd3},
        {1'b1, 16'h1010, 1'b0, 6'd0},
        {1'b1, 16'h8000, 1'b0, 6'd0}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              dbg_en = 1'b0, arm_req = 1'b0, disarm_req = 1'b0;
    logic [2:0]        run_setup = 3'b000;
    logic              loop1_mode = 1'b0, cmpc_en = 1'b0, cmpc_tagged = 1'b0, route_dbg = 1'b0;
    logic [ADDR_W-1:0] cmp_a_addr = A_ADDR, cmp_b_addr = B_ADDR, cmp_c_addr = C_ADDR;
    logic              bus_valid = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              fetch_tag = 1'b0, exec_tag = 1'b0, pipe_flush = 1'b0;
    logic              trace_we, armed, trace_full, dbg_req, swi_req, req_tagged;
    logic [PTR_W-1:0]  trace_waddr;
    logic [ADDR_W-1:0] trace_wdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dbg_trace_brk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut (.*);

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_idle();
        bus_valid = 1'b0; fetch_tag = 1'b0; exec_tag = 1'b0; pipe_flush = 1'b0;
        bus_addr = 16'h0;
    endtask

    task automatic bus(input logic [15:0] a, input logic ft, input logic ex);
        bus_valid = 1'b1; bus_addr = a; fetch_tag = ft; exec_tag = ex; pipe_flush = 1'b0;
        step();
        bus_idle();
    endtask

    task automatic do_arm();
        arm_req = 1'b1; step(); arm_req = 1'b0;
    endtask

    task automatic do_disarm();
        disarm_req = 1'b1; step(); disarm_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        #0;
        // R1: reset state
        chk("R1", "armed", armed, 0);
        chk("R1", "full", trace_full, 0);
        chk("R1", "we", trace_we, 0);
        chk("R1", "waddr", trace_waddr, 0);
        chk("R1", "reqs", {dbg_req, swi_req, req_tagged}, 0);

        // R2: disabled block ignores arm
        do_arm();
        chk("R2", "arm while disabled", armed, 0);
        dbg_en = 1'b1;
        // R2: disarm wins over arm
        arm_req = 1'b1; disarm_req = 1'b1; step(); arm_req = 1'b0; disarm_req = 1'b0;
        chk("R2", "disarm priority", armed, 0);

        // R3/R4 table: end role, address trigger on A/B, no breakpoint
        run_setup = 3'b000;
        do_arm();
        chk("R2", "armed after arm", armed, 1);
        for (int i = 0; i < NVEC; i++) begin
            bus_valid = VEC[i][23]; bus_addr = VEC[i][22:7];
            step();
            bus_idle();
            chk("R3", "table we", trace_we, VEC[i][6]);
            if (VEC[i][6]) begin
                chk("R3", "table waddr", trace_waddr, VEC[i][5:0]);
                chk("R3", "table wdata", trace_wdata, VEC[i][22:7]);
            end
            chk("R8", "no request without brk", {dbg_req, swi_req}, 0);
            if (i == 5) chk("R4", "armed cleared at trigger", armed, 0);
        end

        // R5/R8: end role, opcode trigger with breakpoint, routed to debug
        run_setup = 3'b011; route_dbg = 1'b1;
        do_arm();
        bus(A_ADDR, 1'b1, 1'b0);
        chk("R5", "fetch alone no trigger", armed, 1);
        chk("R5", "fetch captured", trace_we, 1);
        bus(16'h1234, 1'b0, 1'b1);
        chk("R5", "exec trigger disarms", armed, 0);
        chk("R5", "exec cycle captured at 1", trace_waddr, 1);
        chk("R8", "dbg_req tagged trigger", dbg_req, 1);
        chk("R8", "req_tagged opcode", req_tagged, 1);
        chk("R12", "swi quiet when routed to dbg", swi_req, 0);

        // R5: flush discards pending tag
        route_dbg = 1'b0;
        do_arm();
        bus(B_ADDR, 1'b1, 1'b0);
        pipe_flush = 1'b1; step(); pipe_flush = 1'b0;
        exec_tag = 1'b1; step(); exec_tag = 1'b0;
        chk("R5", "flushed tag no request", {dbg_req, swi_req}, 0);
        chk("R5", "flushed tag keeps armed", armed, 1);
        do_disarm();

        // R8: end role address trigger with breakpoint is forced
        run_setup = 3'b001;
        do_arm();
        bus(B_ADDR, 1'b0, 1'b0);
        chk("R8", "forced swi at address trigger", swi_req, 1);
        chk("R8", "forced kind", req_tagged, 0);
        chk("R12", "dbg quiet when routed to swi", dbg_req, 0);

        // R6/R7/R9: begin role, address trigger, breakpoint at exhaustion
        run_setup = 3'b101;
        do_arm();
        bus(16'h2000, 1'b0, 1'b0);
        chk("R6", "no capture before trigger", trace_we, 0);
        bus(A_ADDR, 1'b0, 1'b0);
        chk("R6", "trigger captured", trace_we, 1);
        chk("R6", "trigger at entry 0", trace_waddr, 0);
        chk("R9", "no request at trigger", swi_req, 0);
        for (int i = 1; i < DEPTH; i++) begin
            bus(16'h3000 + 16'(i), 1'b0, 1'b0);
            if (i == DEPTH - 2) begin
                chk("R9", "no request one before full", swi_req, 0);
                chk("R7", "not full yet", trace_full, 0);
            end
        end
        chk("R7", "last entry", trace_waddr, DEPTH - 1);
        chk("R7", "full set", trace_full, 1);
        chk("R7", "begin run disarmed", armed, 0);
        chk("R9", "forced swi at full", swi_req, 1);
        chk("R9", "forced kind at full", req_tagged, 0);
        bus(16'h3100, 1'b0, 1'b0);
        chk("R7", "capture stopped", trace_we, 0);

        // R7: end role wraps
        run_setup = 3'b000;
        do_arm();
        chk("R2", "arm clears full", trace_full, 0);
        for (int i = 0; i < DEPTH; i++) bus(16'h4000 + 16'(i), 1'b0, 1'b0);
        chk("R7", "end role full", trace_full, 1);
        chk("R7", "end role stays armed", armed, 1);
        bus(16'h4100, 1'b0, 1'b0);
        chk("R7", "wrap to entry 0", trace_waddr, 0);
        chk("R3", "wrap data", trace_wdata, 16'h4100);

        // R10: comparator C forced while armed, armed unchanged
        cmpc_en = 1'b1; cmpc_tagged = 1'b0; route_dbg = 1'b1;
        bus(C_ADDR, 1'b0, 1'b0);
        chk("R10", "C forced dbg_req", dbg_req, 1);
        chk("R10", "C forced kind", req_tagged, 0);
        chk("R10", "C keeps armed", armed, 1);
        do_disarm();
        bus(C_ADDR, 1'b0, 1'b0);
        chk("R10", "C while disarmed", dbg_req, 1);
        chk("R10", "C does not arm", armed, 0);

        // R11: loop1 suppresses C
        loop1_mode = 1'b1;
        bus(C_ADDR, 1'b0, 1'b0);
        chk("R11", "loop1 no request", {dbg_req, swi_req}, 0);
        loop1_mode = 1'b0;

        // R10: C tagged via fetch then exec
        cmpc_tagged = 1'b1; route_dbg = 1'b0;
        bus(C_ADDR, 1'b1, 1'b0);
        chk("R10", "C tagged not at fetch", swi_req, 0);
        exec_tag = 1'b1; step(); exec_tag = 1'b0;
        chk("R10", "C tagged at exec", swi_req, 1);
        chk("R10", "C tagged kind", req_tagged, 1);
        step();
        chk("R12", "request is a pulse", swi_req, 0);

        // R2: dropping enable disarms
        cmpc_en = 1'b0;
        do_arm();
        dbg_en = 1'b0; step();
        chk("R2", "disable disarms", armed, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule